// File: doc/BRIEF.md
# Clock Generator Configuration Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C, standard mode, up to 100 kbit/s). It holds six byte-wide configuration registers that steer a multi-output clock generator: output enables, the frequency selection and the spread-spectrum controls. SCL and SDA are brought into the system clock domain through two-flop synchronizers. START and STOP are recognised as SDA edges while SCL is high. The block only ever pulls SDA low and never holds SCL.

A write transaction carries the address byte D2h, then a command byte and a count byte. Both are acknowledged and thrown away. Any number of data bytes follow, zero included, and they land in registers 0, 1, 2 and so on. A read transaction carries the address byte D3h. The target answers first with a count byte of 06h and then with the registers in ascending order. Each new transaction starts again at register 0.

Register 0 is decoded inside the block. Its bit 3 picks the frequency select: 0 passes the strapped pins through, and 1 uses register bits 6:4. Its bits 1, 2 and 7 drive the spread-spectrum enable, the spread direction and the spread amount.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: Only the 7-bit address 69h (address bytes D2h for write and D3h for read) is acknowledged. Any other address gets no acknowledge, and the registers keep their values.
- R2: In a write, the two bytes after the address (command and count) are acknowledged and change no register.
- R3: Write data bytes are stored in registers 0, 1, 2 and onward in order. A write with zero data bytes changes no register, and at most one register changes per clock.
- R4: The target acknowledges every byte of an addressed transaction by pulling SDA low through the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R5: Data bytes written after register 5 has been filled are acknowledged and discarded.
- R6: A read returns 06h first, then registers 0 to 5 in order, then FFh for every byte after register 5. The master's not-acknowledge ends the read.
- R7: After reset, register 0 (bits 7:0 of cfgBytes) is 00h and registers 1 to 5 are FFh.
- R8: freqSel equals strapSel when register 0 bit 3 is 0, and equals register 0 bits 6:4 when that bit is 1.
- R9: spreadEn follows register 0 bit 1, spreadDown follows bit 2 (1 = down spread, 0 = centre spread), and spreadWide follows bit 7.
- R10: SDA is released outside acknowledge and read-data bits. A STOP returns the target to idle. A repeated START begins a new transaction at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed SCL bus level |
| sdaIn | input | 1 | Sensed SDA bus level |
| strapSel | input | 3 | Frequency select from strap pins |
| sdaDrvLow | output | 1 | 1 pulls SDA low (open-drain control) |
| cfgBytes | output | 48 | Register contents, register i in bits 8i+7:8i |
| freqSel | output | 3 | Selected frequency code |
| spreadEn | output | 1 | Spread-spectrum enable |
| spreadDown | output | 1 | 1 down spread, 0 centre spread |
| spreadWide | output | 1 | Spread amount select |

## Verification
Directed transactions isolate single cases:
- a foreign address, which shows that non-matching traffic is ignored;
- a write with no data bytes, which shows that the command and count bytes are dropped;
- an overlong write and an overlong read, which expose the end of the register bank;
- back-to-back transactions joined by a repeated START, which show that the register pointer restarts.

Randomised writes of random length and data, with random strap values, are each followed by a read of random length. The bench checks every acknowledge, every read byte and the decoded outputs against a byte model of the registers. This separates a wrong storage order, a pointer that does not saturate, and an unfaithful frequency-source mux.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // Per-cycle commands from the control FSM to the datapath
  typedef struct packed {
    logic clearPtr;   // new transaction: pointer back to register 0
    logic shiftIn;    // capture one received bit
    logic inBit;      // value of the received bit
    logic storeByte;  // write received byte at pointer
    logic loadCount;  // load count byte into transmitter
    logic loadReg;    // load register at pointer into transmitter
    logic shiftOut;   // advance transmitter by one bit
    logic drvAck;     // hold SDA low for acknowledge
    logic drvTx;      // transmitter owns SDA
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } busState_t;

endpackage

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  output cfgStrobe_t strb
);

  // Byte index within a write: 0 address, 1 command, 2 count, 3 data
  localparam logic [1:0] IDX_DATA = 2'd3;

  logic sclMeta, sclS, sclD;
  logic sdaMeta, sdaS, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclD} <= 3'b111;
      {sdaMeta, sdaS, sdaD} <= 3'b111;
    end else begin
      sclMeta <= sclIn;
      sclS    <= sclMeta;
      sclD    <= sclS;
      sdaMeta <= sdaIn;
      sdaS    <= sdaMeta;
      sdaD    <= sdaS;
    end
  end

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  busState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic [1:0] byteIdx, byteIdxN;
  logic       isRead, isReadN;
  logic       nack, nackN;

  always_comb begin
    strb        = '0;
    strb.inBit  = sdaS;
    strb.drvAck = (state == ST_ACK);
    strb.drvTx  = (state == ST_SEND);
    stateN      = state;
    bitCntN     = bitCnt;
    byteIdxN    = byteIdx;
    isReadN     = isRead;
    nackN       = nack;
    if (startCond) begin
      stateN        = ST_RECV;
      bitCntN       = '0;
      byteIdxN      = '0;
      isReadN       = 1'b0;
      strb.clearPtr = 1'b1;
    end else if (stopCond) begin
      stateN = ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (byteIdx == 2'd0) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateN  = ST_ACK;
                isReadN = rxByte[0];
              end else begin
                stateN = ST_IDLE;
              end
            end else begin
              stateN         = ST_ACK;
              strb.storeByte = (byteIdx == IDX_DATA);
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (byteIdx != IDX_DATA) byteIdxN = byteIdx + 2'd1;
            if (isRead) begin
              stateN         = ST_SEND;
              strb.loadCount = 1'b1;
            end else begin
              stateN = ST_RECV;
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = ST_MACK;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntN       = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) nackN = sdaS;
          if (sclFall) begin
            if (nack) begin
              stateN = ST_IDLE;
            end else begin
              stateN       = ST_SEND;
              bitCntN      = '0;
              strb.loadReg = 1'b1;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      isRead  <= 1'b0;
      nack    <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      byteIdx <= byteIdxN;
      isRead  <= isReadN;
      nack    <= nackN;
    end
  end

endmodule

// File: rtl/clkcfg_i2c_datapath.sv
module clkcfg_i2c_datapath
  import clkcfg_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  output logic [7:0]            rxByte,
  output logic [NUM_REGS*8-1:0] cfgBytes,
  output logic                  sdaDrvLow
);

  localparam int          PTR_W    = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
  localparam logic [7:0]  COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [7:0]  PAST_END   = 8'hFF;

  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] regPtr;
  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       readByte;
  logic             ptrInRange;

  assign ptrInRange = (regPtr < PTR_END);
  assign readByte   = ptrInRange ? regFile[regPtr] : PAST_END;
  assign rxByte     = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.inBit};
  end

  // Pointer saturates one past the last register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regPtr <= '0;
    else if (strb.clearPtr) regPtr <= '0;
    else if ((strb.storeByte || strb.loadReg) && ptrInRange) regPtr <= regPtr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= (i == 0) ? REG0_INIT : REGN_INIT;
    end else if (strb.storeByte && ptrInRange) begin
      regFile[regPtr] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (strb.loadCount) txShift <= COUNT_BYTE;
    else if (strb.loadReg) txShift <= readByte;
    else if (strb.shiftOut) txShift <= {txShift[6:0], 1'b1};
  end

  assign sdaDrvLow = strb.drvAck | (strb.drvTx & ~txShift[7]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_pack
    assign cfgBytes[g*8 +: 8] = regFile[g];
  end

endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
  import clkcfg_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [2:0]            strapSel,
  output logic                  sdaDrvLow,
  output logic [NUM_REGS*8-1:0] cfgBytes,
  output logic [2:0]            freqSel,
  output logic                  spreadEn,
  output logic                  spreadDown,
  output logic                  spreadWide
);

  cfgStrobe_t strb;
  logic [7:0] rxByte;
  logic [7:0] ctl0;

  clkcfg_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .strb   (strb)
  );

  clkcfg_i2c_datapath #(
    .NUM_REGS  (NUM_REGS),
    .REG0_INIT (REG0_INIT),
    .REGN_INIT (REGN_INIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxByte    (rxByte),
    .cfgBytes  (cfgBytes),
    .sdaDrvLow (sdaDrvLow)
  );

  assign ctl0       = cfgBytes[7:0];
  assign freqSel    = ctl0[3] ? ctl0[6:4] : strapSel;
  assign spreadEn   = ctl0[1];
  assign spreadDown = ctl0[2];
  assign spreadWide = ctl0[7];

endmodule

// File: rtl/clkcfg_i2c_target_chk.sv
module clkcfg_i2c_target_chk #(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDrvLow,
  input logic [NUM_REGS*8-1:0] cfgBytes
);

  function automatic logic [NUM_REGS*8-1:0] resetImage();
    logic [NUM_REGS*8-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = (i == 0) ? REG0_INIT : REGN_INIT;
    return v;
  endfunction

  function automatic logic [NUM_REGS-1:0] changedBytes(logic [NUM_REGS*8-1:0] a,
                                                      logic [NUM_REGS*8-1:0] b);
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) m[i] = (a[i*8 +: 8] != b[i*8 +: 8]);
    return m;
  endfunction

  // R7: registers hold their reset image while reset is asserted
  p_reset_values_r7: assert property (@(posedge clk)
    !rstN |-> cfgBytes == resetImage());

  // R3: a single register is written per clock at most
  p_single_byte_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(changedBytes(cfgBytes, $past(cfgBytes))) <= 1);

  // R4: SDA drive starts only while SCL is low
  p_drive_on_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> !sclIn);

  // R4: SDA drive is steady while SCL stays high
  p_sda_steady_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaDrvLow));

endmodule

bind clkcfg_i2c_target clkcfg_i2c_target_chk #(
  .NUM_REGS  (NUM_REGS),
  .REG0_INIT (REG0_INIT),
  .REGN_INIT (REGN_INIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaDrvLow (sdaDrvLow),
  .cfgBytes  (cfgBytes)
);

// File: tb/clkcfg_i2c_target_bench.sv
module clkcfg_i2c_target_bench;

  localparam int Q = 6;  // system clocks per quarter SCL bit

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b1;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaBus;
  logic [2:0]  strapSel = 3'd5;
  logic        sdaDrvLow;
  logic [47:0] cfgBytes;
  logic [2:0]  freqSel;
  logic        spreadEn, spreadDown, spreadWide;

  assign sdaBus = sdaM & ~sdaDrvLow;

  clkcfg_i2c_target u_clkcfg_i2c_target (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .strapSel   (strapSel),
    .sdaDrvLow  (sdaDrvLow),
    .cfgBytes   (cfgBytes),
    .freqSel    (freqSel),
    .spreadEn   (spreadEn),
    .spreadDown (spreadDown),
    .spreadWide (spreadWide)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [6];
  logic [7:0] wdata [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(2 * Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    acked = ~sdaBus;
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1; tick(Q);
      b[i] = sdaBus;
      tick(Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = ~ackIt; tick(Q);
    sclM = 1'b1; tick(2 * Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] expRead(input int i);
    return (i < 6) ? model[i] : 8'hFF;
  endfunction

  function automatic logic [2:0] expFreq();
    return model[0][3] ? model[0][6:4] : strapSel;
  endfunction

  // Write body after a START: address, command, count, n data bytes
  task automatic writeBody(input int n);
    logic a;
    sendByte(8'hD2, a);               chk("R4 write address ack", a, 1'b1);
    sendByte(8'($urandom), a);        chk("R2 command byte ack", a, 1'b1);
    sendByte(8'($urandom), a);        chk("R2 count byte ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      sendByte(wdata[i], a);
      if (i < 6) begin
        chk("R4 data byte ack", a, 1'b1);
        model[i] = wdata[i];
      end else begin
        chk("R5 excess byte ack", a, 1'b1);
      end
    end
  endtask

  task automatic readBody(input int n);
    logic a;
    logic [7:0] b;
    sendByte(8'hD3, a);               chk("R4 read address ack", a, 1'b1);
    recvByte(n != 0, b);              chk("R6 count byte", b, 8'h06);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      chk("R6 read data", b, expRead(i));
    end
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 6; i++) chk(req, cfgBytes[i*8 +: 8], model[i]);
  endtask

  task automatic checkDecode();
    chk("R8 frequency select", freqSel, expFreq());
    chk("R9 spread enable", spreadEn, model[0][1]);
    chk("R9 spread direction", spreadDown, model[0][2]);
    chk("R9 spread amount", spreadWide, model[0][7]);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    logic a;
    void'($urandom(32'h5EED_1234));
    model[0] = 8'h00;
    for (int i = 1; i < 6; i++) model[i] = 8'hFF;

    #1 rstN = 1'b0;
    tick(5);
    // R7: reset image
    checkRegs("R7 reset value");
    chk("R10 SDA released after reset", sdaDrvLow, 1'b0);
    checkDecode();
    rstN = 1'b1;
    tick(5);

    // R1: foreign address ignored
    busStart();
    sendByte(8'hA4, a);               chk("R1 foreign address no ack", a, 1'b0);
    sendByte(8'h55, a);               chk("R1 no ack after mismatch", a, 1'b0);
    busStop();
    checkRegs("R1 registers untouched");

    // R3 and R2: write with no data bytes
    busStart(); writeBody(0); busStop();
    checkRegs("R3 zero data bytes");
    chk("R10 SDA released after STOP", sdaDrvLow, 1'b0);

    // R8/R9: register source for frequency, spread bits
    wdata[0] = 8'hBE; wdata[1] = 8'h0F; wdata[2] = 8'hA5;
    busStart(); writeBody(3); busStop();
    checkRegs("R3 sequential fill");
    checkDecode();

    // R5: overlong write
    for (int i = 0; i < 9; i++) wdata[i] = 8'(8'h11 * (i + 1));
    busStart(); writeBody(9); busStop();
    checkRegs("R5 excess bytes dropped");

    // R6: overlong read
    busStart(); readBody(8); busStop();

    // R10: repeated START restarts the pointer
    wdata[0] = 8'h7C;
    busStart(); writeBody(1);
    wdata[0] = 8'h46;
    busStart(); writeBody(1); busStop();
    checkRegs("R10 repeated start restarts at register 0");
    busStart(); writeBody(0); busStart(); readBody(3); busStop();

    // R8: strap pins in control when bit 3 clear
    wdata[0] = 8'h70; strapSel = 3'd2;
    busStart(); writeBody(1); busStop();
    checkDecode();

    for (int it = 0; it < 22; it++) begin
      int nw, nr;
      nw = $urandom_range(0, 8);
      nr = $urandom_range(0, 8);
      strapSel = 3'($urandom);
      for (int i = 0; i < nw; i++) wdata[i] = 8'($urandom);
      busStart(); writeBody(nw); busStop();
      checkRegs("R3 random write");
      checkDecode();
      busStart(); readBody(nr); busStop();
    end

    finishRun();
  end

endmodule